// File: doc/BRIEF.md
# 100BASE-TX Receive Framer

This block sits behind the descrambler of a 100BASE-TX receiver. It takes one descrambled line bit per `bit_vld` cycle, looks for the two-symbol start delimiter in a ten-bit sliding window, and fixes the five-bit code-group boundary for the rest of the frame on that match. Each code group is then decoded back to a nibble and presented on the MII-style receive outputs (`rx_dv`, `rx_er`, `rxd`), together with a one-cycle `rx_en` strobe that marks each receive-clock period.

Between frames the line should carry only ones. Bursts of zeros that do not form the start delimiter are reported as false carrier. After a false carrier the input is ignored until a run of ten ones restores idle. Inside a frame the framer flags invalid code groups, an idle stream that arrives without an end delimiter, and loss of descrambler lock (`scr_lock` low).

A saturating error counter tallies every receive period that shows `rx_er` high. It clears on a read pulse and whenever the speed-select input changes.

Top module: `rxf_framer`

## Requirements
- R1: Outside a frame, `rx_en` pulses once per five accepted bits and shows `rx_dv`=0, `rx_er`=0, `rxd`=0000. All three outputs change only in a cycle where `rx_en` is high.
- R2: While hunting, a window whose ten newest bits are 1100010001 (oldest first) produces an `rx_en` pulse at once with `rx_dv`=1, `rx_er`=0, `rxd`=0101. The next five bits form the first code group.
- R3: Inside a frame, each code group (first bit received = MSB) decodes as 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F. The result is shown with `rx_dv`=1 and `rx_er`=0.
- R4: Inside a frame, a group that is neither a data code nor the end code 01101 shows `rx_dv`=1, `rx_er`=1, `rxd`=0110, and the frame continues.
- R5: The end code 01101 shows `rx_dv`=0 and `rx_er`=0. The following group is discarded, and the framer then hunts again.
- R6: An idle group 11111 inside a frame is an error (R4). A second idle group in a row is shown as an error with `rx_dv`=1, the next period shows `rx_dv`=0, and the framer hunts for a new start delimiter.
- R7: A data group decoded while `scr_lock` is low shows its nibble with `rx_dv`=1 and `rx_er`=1.
- R8: While hunting, the window is judged when the oldest zero of a zero event sits eighth-newest, with two ones older than it. If the window is not the start delimiter and holds two zeros at least two positions apart, every period shows `rx_dv`=0, `rx_er`=1, `rxd`=1110. Two adjacent zeros alone raise nothing.
- R9: After a false carrier, all input, including a start delimiter, is ignored and the false-carrier indication repeats in each period until ten consecutive ones have arrived. The framer then hunts again.
- R10: Once raised, `rx_er` stays high until at least the next `rx_en` pulse.
- R11: `err_cnt` adds one for each `rx_en` pulse that shows `rx_er`=1. It holds at all ones rather than wrapping.
- R12: `err_cnt` returns to zero the cycle after `cnt_clr` is high, and the cycle after `speed_100` changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | `bit_in` carries a new line bit this cycle |
| bit_in | input | 1 | Descrambled serial bit |
| scr_lock | input | 1 | Descrambler is synchronized |
| speed_100 | input | 1 | Speed select; any change clears the counter |
| cnt_clr | input | 1 | Counter read pulse; clears the counter |
| rx_en | output | 1 | One-cycle strobe marking a receive period |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error / false carrier |
| rxd | output | 4 | Receive nibble |
| err_cnt | output | 16 | Saturating receive-error count |

## Verification
On every cycle, the assertions check four things: the outputs hold between strobes (which also keeps an error visible for a full period), a rising `rx_dv` always carries the 0101 start nibble, `rx_er` without `rx_dv` always carries the false-carrier code, and the counter neither wraps past all ones nor survives a clear. Other behaviour needs the bench's bit streams. This covers the whole decode table, where the window judgement falls for adjacent and separated zeros, and the ten-ones release that ignores an embedded start delimiter. It also covers the two-idle exit and its recovery, lock loss, and saturation on a narrow counter.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FALSE = 2'd1,
        ST_FRAME = 2'd2,
        ST_TAIL  = 2'd3
    } rxf_state_e;

    localparam logic [9:0] SOF_PAIR = 10'b11000_10001;
    localparam logic [4:0] CG_END   = 5'b01101;
    localparam logic [4:0] CG_IDLE  = 5'b11111;

    localparam logic [3:0] NIB_SOF  = 4'b0101;
    localparam logic [3:0] NIB_FC   = 4'b1110;
    localparam logic [3:0] NIB_BAD  = 4'b0110;

endpackage

// File: rtl/rxf_window.sv
module rxf_window #(
    parameter int WIN_BITS = 10,
    parameter int GRP_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                bit_in,
    input  logic                flush,
    output logic [GRP_BITS-1:0] grp,
    output logic                judge,
    output logic                sof_hit,
    output logic                split_zeros
);
    import rxf_pkg::*;

    logic [WIN_BITS-1:0] win_q, win_d, win_next, zn;

    always_comb begin
        win_next = {win_q[WIN_BITS-2:0], bit_in};
        zn       = ~win_next;
        grp      = win_next[GRP_BITS-1:0];
        judge    = (win_next[WIN_BITS-2 -: 2] == 2'b10);
        sof_hit  = (win_next == SOF_PAIR);
        split_zeros = 1'b0;
        for (int i = 0; i < WIN_BITS-2; i++) begin
            if (zn[i] && ((zn >> (i+2)) != '0))
                split_zeros = 1'b1;
        end
        win_d = win_q;
        if (flush)
            win_d = '1;
        else if (shift_en)
            win_d = win_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= win_d;
    end

endmodule

// File: rtl/rxf_cg_decode.sv
module rxf_cg_decode (
    input  logic [4:0] cg,
    output logic [3:0] nib,
    output logic       is_data,
    output logic       is_end,
    output logic       is_idle
);
    import rxf_pkg::*;

    always_comb begin
        is_data = 1'b1;
        nib     = 4'h0;
        case (cg)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            default:  is_data = 1'b0;
        endcase
        is_end  = (cg == CG_END);
        is_idle = (cg == CG_IDLE);
    end

endmodule

// File: rtl/rxf_err_count.sv
module rxf_err_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    input  logic             speed,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             speed_q, speed_d;
    logic             wipe;

    always_comb begin
        speed_d = speed;
        wipe    = clr || (speed != speed_q);
        if (wipe)
            cnt_d = {{(CNT_W-1){1'b0}}, inc};
        else if (cnt_q == '1)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, inc};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            speed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            speed_q <= speed_d;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !clr && speed == speed_q) |=> (cnt_q == '1)); // R11

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q <= 1)); // R12

endmodule

// File: rtl/rxf_framer.sv
module rxf_framer #(
    parameter int WIN_BITS = 10,
    parameter int GRP_BITS = 5,
    parameter int RUN_LEN  = 10,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             scr_lock,
    input  logic             speed_100,
    input  logic             cnt_clr,
    output logic             rx_en,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [3:0]       rxd,
    output logic [CNT_W-1:0] err_cnt
);
    import rxf_pkg::*;

    localparam int PH_W = $clog2(GRP_BITS);
    localparam int ON_W = $clog2(RUN_LEN + 1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(GRP_BITS - 1);
    localparam logic [ON_W-1:0] ONE_LAST = ON_W'(RUN_LEN - 1);

    typedef struct packed {
        rxf_state_e      st;
        logic [PH_W-1:0] phase;
        logic [ON_W-1:0] ones;
        logic            idle_seen;
        logic            stb;
        logic            dv;
        logic            er;
        logic [3:0]      rxd;
    } rxf_regs_t;

    rxf_regs_t q, d;

    logic [GRP_BITS-1:0] grp;
    logic judge, sof_hit, split_zeros, flush;
    logic [3:0] dec_nib;
    logic dec_data, dec_end, dec_idle;
    logic grp_done;

    rxf_window #(.WIN_BITS(WIN_BITS), .GRP_BITS(GRP_BITS)) u_win (
        .clk(clk), .rst_n(rst_n), .shift_en(bit_vld), .bit_in(bit_in),
        .flush(flush), .grp(grp), .judge(judge), .sof_hit(sof_hit),
        .split_zeros(split_zeros)
    );

    rxf_cg_decode u_dec (
        .cg(grp), .nib(dec_nib), .is_data(dec_data),
        .is_end(dec_end), .is_idle(dec_idle)
    );

    rxf_err_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(d.stb && d.er), .clr(cnt_clr),
        .speed(speed_100), .cnt(err_cnt)
    );

    always_comb begin
        d        = q;
        d.stb    = 1'b0;
        flush    = 1'b0;
        grp_done = bit_vld && (q.phase == PH_LAST);
        if (bit_vld)
            d.phase = (q.phase == PH_LAST) ? '0 : q.phase + 1'b1;

        case (q.st)
            ST_HUNT: begin
                if (bit_vld && judge) begin
                    if (sof_hit) begin
                        d.st        = ST_FRAME;
                        d.phase     = '0;
                        d.idle_seen = 1'b0;
                        d.stb       = 1'b1;
                        d.dv        = 1'b1;
                        d.er        = 1'b0;
                        d.rxd       = NIB_SOF;
                    end else if (split_zeros) begin
                        d.st   = ST_FALSE;
                        d.ones = '0;
                    end
                end
                if (grp_done && d.st != ST_FRAME) begin
                    d.stb = 1'b1;
                    d.dv  = 1'b0;
                    d.er  = (d.st == ST_FALSE);
                    d.rxd = (d.st == ST_FALSE) ? NIB_FC : 4'h0;
                end
            end
            ST_FALSE: begin
                if (bit_vld) begin
                    if (!bit_in) begin
                        d.ones = '0;
                    end else if (q.ones == ONE_LAST) begin
                        d.ones = '0;
                        d.st   = ST_HUNT;
                        flush  = 1'b1;
                    end else begin
                        d.ones = q.ones + 1'b1;
                    end
                end
                if (grp_done) begin
                    d.stb = 1'b1;
                    d.dv  = 1'b0;
                    d.er  = (d.st == ST_FALSE);
                    d.rxd = (d.st == ST_FALSE) ? NIB_FC : 4'h0;
                end
            end
            ST_FRAME: begin
                if (grp_done) begin
                    d.stb = 1'b1;
                    if (dec_data) begin
                        d.dv        = 1'b1;
                        d.er        = !scr_lock;
                        d.rxd       = dec_nib;
                        d.idle_seen = 1'b0;
                    end else if (dec_end) begin
                        d.dv  = 1'b0;
                        d.er  = 1'b0;
                        d.rxd = 4'h0;
                        d.st  = ST_TAIL;
                    end else begin
                        d.dv  = 1'b1;
                        d.er  = 1'b1;
                        d.rxd = NIB_BAD;
                        d.idle_seen = dec_idle;
                        if (dec_idle && q.idle_seen) begin
                            d.st  = ST_HUNT;
                            flush = 1'b1;
                        end
                    end
                end
            end
            default: begin
                if (grp_done) begin
                    d.stb = 1'b1;
                    d.dv  = 1'b0;
                    d.er  = 1'b0;
                    d.rxd = 4'h0;
                    d.st  = ST_HUNT;
                    flush = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_HUNT;
            q.phase     <= '0;
            q.ones      <= '0;
            q.idle_seen <= 1'b0;
            q.stb       <= 1'b0;
            q.dv        <= 1'b0;
            q.er        <= 1'b0;
            q.rxd       <= 4'h0;
        end else begin
            q <= d;
        end
    end

    assign rx_en = q.stb;
    assign rx_dv = q.dv;
    assign rx_er = q.er;
    assign rxd   = q.rxd;

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (rx_en || $stable({rx_dv, rx_er, rxd}))); // R10

    AST_DV_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> (rxd == NIB_SOF && rx_en)); // R2

    AST_FC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_er && !rx_dv) |-> (rxd == NIB_FC)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !rx_dv && !rx_er) |-> (rxd == 4'h0)); // R1

endmodule

// File: tb/tb_rxf_framer.sv
module tb_rxf_framer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0, bit_in = 1'b1, scr_lock = 1'b1;
    logic speed_100 = 1'b1, cnt_clr = 1'b0;
    logic rx_en, rx_dv, rx_er;
    logic [3:0] rxd;
    logic [15:0] err_cnt;
    logic s_en, s_dv, s_er;
    logic [3:0] s_rxd;
    logic [3:0] s_cnt;

    int total = 0, bad = 0;
    int n_stb = 0, n_dv = 0, n_er = 0, n_fc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxf_framer dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .scr_lock(scr_lock), .speed_100(speed_100), .cnt_clr(cnt_clr),
        .rx_en(rx_en), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd), .err_cnt(err_cnt)
    );

    rxf_framer #(.CNT_W(4)) dut_sat (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .scr_lock(scr_lock), .speed_100(speed_100), .cnt_clr(cnt_clr),
        .rx_en(s_en), .rx_dv(s_dv), .rx_er(s_er), .rxd(s_rxd), .err_cnt(s_cnt)
    );

    // {code[4:0], dv, er, rxd[3:0]}
    localparam logic [10:0] TBL [0:20] = '{
        {5'b11110, 2'b10, 4'h0}, {5'b01001, 2'b10, 4'h1}, {5'b10100, 2'b10, 4'h2},
        {5'b10101, 2'b10, 4'h3}, {5'b01010, 2'b10, 4'h4}, {5'b01011, 2'b10, 4'h5},
        {5'b01110, 2'b10, 4'h6}, {5'b01111, 2'b10, 4'h7}, {5'b10010, 2'b10, 4'h8},
        {5'b10011, 2'b10, 4'h9}, {5'b10110, 2'b10, 4'hA}, {5'b10111, 2'b10, 4'hB},
        {5'b11010, 2'b10, 4'hC}, {5'b11011, 2'b10, 4'hD}, {5'b11100, 2'b10, 4'hE},
        {5'b11101, 2'b10, 4'hF},
        {5'b00000, 2'b11, 4'h6}, {5'b11111, 2'b11, 4'h6}, {5'b01001, 2'b10, 4'h1},
        {5'b11111, 2'b11, 4'h6}, {5'b00100, 2'b11, 4'h6}
    };

    always @(negedge clk) begin
        if (rst_n && rx_en) begin
            n_stb++;
            if (rx_dv) n_dv++;
            if (rx_er) n_er++;
            if (!rx_dv && rx_er && rxd == 4'hE) n_fc++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_cg(input logic [4:0] c);
        for (int i = 4; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_sof();
        send_cg(5'b11000);
        send_cg(5'b10001);
    endtask

    task automatic settle();
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b1;
        #1;
    endtask

    task automatic clr_log();
        n_stb = 0; n_dv = 0; n_er = 0; n_fc = 0;
    endtask

    task automatic end_frame();
        send_cg(5'b01101);
        settle();
        chk(rx_en && !rx_dv && !rx_er, "R5 end code", {rx_dv, rx_er}, 0);
        send_cg(5'b00111);
        settle();
        chk(rx_en && !rx_dv && !rx_er, "R5 tail group", {rx_dv, rx_er}, 0);
        send_ones(15);
        settle();
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state (R1, R11)
        chk(!rx_en, "R1 reset strobe", rx_en, 0);
        chk(!rx_dv && !rx_er, "R1 reset flags", {rx_dv, rx_er}, 0);
        chk(rxd == 4'h0, "R1 reset rxd", rxd, 0);
        chk(err_cnt == 0, "R11 reset count", err_cnt, 0);

        // R1: idle strobe rate
        clr_log();
        send_ones(40);
        settle();
        chk(n_stb == 8, "R1 strobe rate", n_stb, 8);
        chk(n_dv == 0 && n_er == 0, "R1 idle quiet", n_dv + n_er, 0);

        // R2 + table walk (R3, R4, R6)
        send_ones(12);
        send_sof();
        settle();
        chk(rx_en && rx_dv && !rx_er && rxd == 4'h5, "R2 start nibble", rxd, 5);
        for (int k = 0; k < 21; k++) begin
            send_cg(TBL[k][10:6]);
            settle();
            chk(rx_en && rx_dv == TBL[k][5] && rx_er == TBL[k][4] && rxd == TBL[k][3:0],
                (k < 16) ? "R3 decode" : "R4 invalid group",
                {rx_dv, rx_er, rxd}, {TBL[k][5], TBL[k][4], TBL[k][3:0]});
        end
        end_frame();

        // R6: two idle groups end the frame
        send_ones(12);
        send_sof();
        settle();
        send_cg(5'b10100);
        settle();
        send_cg(5'b11111);
        settle();
        chk(rx_dv && rx_er, "R6 first idle", {rx_dv, rx_er}, 3);
        send_cg(5'b11111);
        settle();
        chk(rx_en && rx_dv && rx_er, "R6 second idle", {rx_dv, rx_er}, 3);
        send_ones(5);
        settle();
        chk(rx_en && !rx_dv && !rx_er, "R6 dv dropped", {rx_dv, rx_er}, 0);

        // R6 recovery, then R7 lock loss
        send_ones(12);
        send_sof();
        settle();
        chk(rx_dv && rxd == 4'h5, "R6 hunt after idle exit", rxd, 5);
        scr_lock = 1'b0;
        send_cg(5'b01001);
        settle();
        chk(rx_dv && rx_er && rxd == 4'h1, "R7 lock lost", {rx_dv, rx_er, rxd}, 7'h31);
        scr_lock = 1'b1;
        send_cg(5'b01001);
        settle();
        chk(rx_dv && !rx_er && rxd == 4'h1, "R7 lock back", {rx_dv, rx_er, rxd}, 7'h21);
        end_frame();

        // R8: adjacent zeros raise nothing
        clr_log();
        send_bit(1'b0);
        send_bit(1'b0);
        send_ones(20);
        settle();
        chk(n_er == 0 && n_fc == 0, "R8 adjacent zeros", n_er, 0);

        // R8/R9: separated zeros -> false carrier, start delimiter ignored
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_ones(8);
        settle();
        clr_log();
        send_sof();
        send_ones(8);
        settle();
        chk(n_stb >= 3 && n_fc == n_stb, "R8 false carrier code", n_fc, n_stb);
        chk(n_dv == 0, "R9 start ignored", n_dv, 0);
        send_ones(1);
        settle();
        clr_log();
        send_ones(10);
        settle();
        chk(n_stb == 2 && n_er == 0, "R9 released after ones", n_er, 0);
        send_sof();
        settle();
        chk(rx_en && rx_dv && rxd == 4'h5, "R9 hunt resumes", rxd, 5);
        end_frame();

        // R12 clear, R11 count and saturation
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        #1;
        chk(err_cnt == 0 && s_cnt == 0, "R12 read clear", err_cnt, 0);
        send_ones(12);
        send_sof();
        for (int k = 0; k < 20; k++) send_cg(5'b00000);
        settle();
        chk(err_cnt == 20, "R11 count", err_cnt, 20);
        chk(s_cnt == 4'hF, "R11 saturate", s_cnt, 15);
        end_frame();
        @(negedge clk);
        speed_100 = 1'b0;
        @(negedge clk);
        #1;
        chk(err_cnt == 0, "R12 speed change clear", err_cnt, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule